// File: doc/BRIEF.md
# Descriptor-Driven FIFO Word Unpacker

The unpacker takes 32-bit words from a show-ahead transmit FIFO and hands out characters to a serializer one at a time. Each word yields up to four characters. A list of four step descriptors drives the split, and the list comes from two 20-bit configuration inputs. A step gives the bit where its field starts and the direction in which the bits are gathered. It also gives the field length of one to eight bits. One step may carry an end mark, and that step's character is the last one taken from the word. The unpacker then fetches the next word. This makes byte order, bit order and character size programmable, in place of fixed low-byte-first slicing.

The control is a three-state machine: `ST_IDLE`, `ST_FETCH` and `ST_EMIT`.
- `ST_IDLE`: the configuration is all zero. It moves to `ST_FETCH` once any configuration bit is set.
- `ST_FETCH`: it pops a word when the FIFO is not empty, loads the word, clears the step counter and moves to `ST_EMIT`. It goes back to `ST_IDLE` if the configuration becomes zero.
- `ST_EMIT`: it presents the character for the current step. When that character is accepted, it either advances the step or returns to `ST_FETCH` after the last step. It drops to `ST_IDLE` if the configuration becomes zero.

Characters leave on a valid/ready handshake. The character is right-aligned in an 8-bit bus. The bit the serializer sends first is bit 0.

Top module: `unpk_top`

## Requirements
- R1: A descriptor is 10 bits. Bit 0 is the end mark, bits 3:1 hold the field length minus one, bit 4 selects descending gathering (1) or ascending gathering (0), and bits 9:5 hold the start bit. `cfg_lo[9:0]` is step 0, `cfg_lo[19:10]` is step 1, `cfg_hi[9:0]` is step 2 and `cfg_hi[19:10]` is step 3.
- R2: In ascending mode, character bit k equals word bit start+k for k from 0 to length-1. Character bits at or above the length are 0.
- R3: In descending mode, character bit k equals word bit start-k for k from 0 to length-1. Character bits at or above the length are 0.
- R4: A position that falls outside word bits 0 to 31 reads as 0.
- R5: The step with the end mark gives the last character of the word. Later descriptors are ignored, and the next FIFO word is fetched afterwards.
- R6: If no descriptor carries the end mark and the configuration is not zero, step 3 is treated as the last step.
- R7: While both configuration inputs are zero, `fifo_pop` and `chr_valid` stay low and no FIFO word is consumed.
- R8: While `chr_valid` is high and `chr_ready` is low, `chr_valid` stays high and `chr_data` holds its value. The step only advances when a character is accepted.
- R9: A pop is raised only when the FIFO is not empty. The first character of the popped word is valid in the next cycle. After the last character of a word is accepted, one cycle passes with `chr_valid` low before the next character appears.
- R10: During and just after reset, `chr_valid` and `fifo_pop` are low.
- R11: While the FIFO is empty and no word is held, neither `fifo_pop` nor `chr_valid` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lo | input | 20 | Descriptors for steps 0 (bits 9:0) and 1 (bits 19:10) |
| cfg_hi | input | 20 | Descriptors for steps 2 (bits 9:0) and 3 (bits 19:10) |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_data | input | 32 | Head word of the show-ahead FIFO |
| fifo_pop | output | 1 | Take the head word in this cycle |
| chr_valid | output | 1 | A character is offered |
| chr_ready | input | 1 | The serializer accepts the offered character |
| chr_data | output | 8 | Character, with the first bit to send in bit 0 |

## Verification
A pop seen on the cycle a word becomes available appears as a valid character one clock edge later. An accepted last character is followed by exactly one cycle with `chr_valid` low. The timing scenario samples each of these cycles at the falling edge, right after the rising edge that caused it. Every other scenario checks content and order, not timing. A monitor samples at each falling edge and counts a character as accepted when valid and ready are both high there. Ready only changes shortly after a rising edge, so the sampled handshake is the one the design sees at the next rising edge. A stalled character is compared against the value it had one falling edge earlier.

// File: rtl/unpk_pkg.sv
package unpk_pkg;

    localparam int DESC_W = 10;
    localparam int CFG_W  = 20;

    // Field positions are fixed by the configuration encoding
    typedef struct packed {
        logic [4:0] start;
        logic       msb_first;
        logic [2:0] len_m1;
        logic       stop;
    } step_desc_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EMIT  = 2'd2
    } unpk_state_e;

endpackage

// File: rtl/unpk_step_sel.sv
module unpk_step_sel
    import unpk_pkg::*;
#(
    parameter int N_STEPS = 4,
    parameter int STEP_W  = 2
) (
    input  logic [N_STEPS*DESC_W-1:0] desc_flat,
    input  logic [STEP_W-1:0]         step_idx,
    output step_desc_t                cur_desc,
    output logic                      is_last
);

    step_desc_t tbl [N_STEPS];

    generate
        for (genvar i = 0; i < N_STEPS; i++) begin : g_desc
            assign tbl[i] = step_desc_t'(desc_flat[i*DESC_W +: DESC_W]);
        end
    endgenerate

    assign cur_desc = tbl[step_idx];
    // Final slot closes the word even without an end mark
    assign is_last  = cur_desc.stop || (step_idx == STEP_W'(N_STEPS - 1));

endmodule

// File: rtl/unpk_extract.sv
module unpk_extract
    import unpk_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CHAR_W = 8
) (
    input  logic [WORD_W-1:0] word,
    input  step_desc_t        desc,
    output logic [CHAR_W-1:0] chr
);

    localparam int IW = $clog2(WORD_W);

    generate
        for (genvar k = 0; k < CHAR_W; k++) begin : g_bit
            logic [IW:0] up_pos;
            logic [IW:0] dn_pos;
            logic        up_ok;
            logic        dn_ok;
            logic        in_len;

            assign up_pos = (IW+1)'(desc.start) + (IW+1)'(k);
            assign dn_pos = (IW+1)'(desc.start) - (IW+1)'(k);
            assign up_ok  = up_pos < (IW+1)'(WORD_W);
            assign dn_ok  = !dn_pos[IW];
            assign in_len = (k <= int'(desc.len_m1));

            always_comb begin
                if (!in_len)
                    chr[k] = 1'b0;
                else if (desc.msb_first)
                    chr[k] = dn_ok && word[dn_pos[IW-1:0]];
                else
                    chr[k] = up_ok && word[up_pos[IW-1:0]];
            end
        end
    endgenerate

endmodule

// File: rtl/unpk_ctrl.sv
module unpk_ctrl
    import unpk_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int N_STEPS = 4,
    parameter int STEP_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_nz,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_data,
    input  logic              step_last,
    input  logic              chr_ready,
    output logic              fifo_pop,
    output logic              chr_valid,
    output logic [WORD_W-1:0] word_q,
    output logic [STEP_W-1:0] step_q
);

    unpk_state_e state_q, state_d;
    logic        accept;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state and output decode
    always_comb begin
        state_d   = state_q;
        fifo_pop  = 1'b0;
        chr_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_nz)
                    state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (!cfg_nz)
                    state_d = ST_IDLE;
                else if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    state_d  = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (!cfg_nz)
                    state_d = ST_IDLE;
                else begin
                    chr_valid = 1'b1;
                    if (chr_ready && step_last)
                        state_d = ST_FETCH;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign accept = chr_valid && chr_ready;

    // Word holding register and step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            step_q <= '0;
        end else if (fifo_pop) begin
            word_q <= fifo_data;
            step_q <= '0;
        end else if (accept && !step_last) begin
            step_q <= step_q + STEP_W'(1);
        end
    end

    // R8
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMIT && !accept) |=> $stable(step_q));

    // R9
    gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && step_last) |=> !chr_valid);

    // R5
    refetch_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && step_last && cfg_nz) |=> (state_q == ST_FETCH));

endmodule

// File: rtl/unpk_top.sv
module unpk_top
    import unpk_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int CHAR_W  = 8,
    parameter int N_STEPS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_lo,
    input  logic [CFG_W-1:0]  cfg_hi,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              chr_valid,
    input  logic              chr_ready,
    output logic [CHAR_W-1:0] chr_data
);

    localparam int STEP_W = $clog2(N_STEPS);
    localparam int FLAT_W = N_STEPS * DESC_W;

    logic [FLAT_W-1:0] desc_flat;
    logic              cfg_nz;
    logic              step_last;
    logic [WORD_W-1:0] word_q;
    logic [STEP_W-1:0] step_q;
    step_desc_t        cur_desc;

    assign desc_flat = FLAT_W'({cfg_hi, cfg_lo});
    assign cfg_nz    = |desc_flat;

    unpk_step_sel #(
        .N_STEPS (N_STEPS),
        .STEP_W  (STEP_W)
    ) u_sel (
        .desc_flat (desc_flat),
        .step_idx  (step_q),
        .cur_desc  (cur_desc),
        .is_last   (step_last)
    );

    unpk_ctrl #(
        .WORD_W  (WORD_W),
        .N_STEPS (N_STEPS),
        .STEP_W  (STEP_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_nz     (cfg_nz),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .step_last  (step_last),
        .chr_ready  (chr_ready),
        .fifo_pop   (fifo_pop),
        .chr_valid  (chr_valid),
        .word_q     (word_q),
        .step_q     (step_q)
    );

    unpk_extract #(
        .WORD_W (WORD_W),
        .CHAR_W (CHAR_W)
    ) u_ext (
        .word (word_q),
        .desc (cur_desc),
        .chr  (chr_data)
    );

    // R7
    zero_cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lo == '0 && cfg_hi == '0) |-> (!fifo_pop && !chr_valid));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && !chr_ready) |=>
            (!$stable(desc_flat) || (chr_valid && $stable(chr_data))));

    // R9
    pop_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> (chr_valid || !cfg_nz));

    // R9
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

endmodule

// File: tb/sim_unpk_top.sv
module sim_unpk_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] cfg_lo = '0;
    logic [19:0] cfg_hi = '0;
    logic        fifo_empty;
    logic [31:0] fifo_data;
    logic        fifo_pop;
    logic        chr_valid;
    logic        chr_ready = 1'b1;
    logic [7:0]  chr_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // FIFO model
    logic [31:0] fmem [256];
    int          f_wr = 0;
    int          f_rd = 0;
    assign fifo_empty = (f_rd == f_wr);
    assign fifo_data  = fmem[f_rd % 256];
    always @(posedge clk) if (fifo_pop) f_rd <= f_rd + 1;

    // Expected characters
    logic [7:0] exp_q [1024];
    int         e_wr = 0;
    int         e_rd = 0;

    // Ready: 0 always high, 1 pseudo-random, 2 held low
    int         rdy_mode = 0;
    logic [7:0] lfsr = 8'hA5;

    always #10 clk = ~clk;

    unpk_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_lo     (cfg_lo),
        .cfg_hi     (cfg_hi),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .fifo_pop   (fifo_pop),
        .chr_valid  (chr_valid),
        .chr_ready  (chr_ready),
        .chr_data   (chr_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    always @(posedge clk) begin
        #1;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        chr_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : 1'b0;
    end

    // Monitor: accepted characters in order, stalled characters held (R8)
    bit         stall_pend = 0;
    logic [7:0] stall_val;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (stall_pend)
                chk(chr_valid && chr_data == stall_val, "R8 stall hold",
                    {chr_valid, chr_data}, {1'b1, stall_val});
            stall_pend = chr_valid && !chr_ready;
            stall_val  = chr_data;
            if (chr_valid && chr_ready) begin
                if (e_rd < e_wr)
                    chk(chr_data == exp_q[e_rd % 1024], "R2/R3 char content", chr_data, exp_q[e_rd % 1024]);
                else
                    chk(0, "R5 unexpected char", chr_data, 0);
                e_rd++;
            end
        end
    end

    function automatic logic [9:0] mk(input int st, input bit msb, input int lm1, input bit stp);
        return {st[4:0], msb, lm1[2:0], stp};
    endfunction

    function automatic logic [7:0] ref_char(input logic [31:0] w, input logic [9:0] d);
        logic [7:0] c = '0;
        int st  = int'(d[9:5]);
        int len = int'(d[3:1]) + 1;
        for (int k = 0; k < 8; k++) begin
            int p = d[4] ? st - k : st + k;
            if (k < len && p >= 0 && p < 32) c[k] = w[p];
        end
        return c;
    endfunction

    // Push a word and its expected characters for a given configuration
    task automatic push(input logic [31:0] w, input logic [19:0] lo, input logic [19:0] hi);
        logic [9:0] d [4];
        d[0] = lo[9:0]; d[1] = lo[19:10]; d[2] = hi[9:0]; d[3] = hi[19:10];
        fmem[f_wr % 256] = w;
        f_wr++;
        for (int s = 0; s < 4; s++) begin
            exp_q[e_wr % 1024] = ref_char(w, d[s]);
            e_wr++;
            if (d[s][0]) break;
        end
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while ((e_rd != e_wr || f_rd != f_wr) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        chk(e_rd == e_wr, tag, e_rd, e_wr);
        chk(f_rd == f_wr, tag, f_rd, f_wr);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!chr_valid && !fifo_pop, "R10 reset outputs", {chr_valid, fifo_pop}, 0);
    endtask

    task automatic t_zero_cfg();
        bit seen = 0;
        logic [19:0] lo = {10'd0, mk(0, 0, 7, 1)};
        push(32'h0000_0041, lo, '0);
        push(32'h0000_0042, lo, '0);
        push(32'h0000_0043, lo, '0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (chr_valid || fifo_pop) seen = 1;
        end
        chk(!seen, "R7 zero cfg quiet", seen, 0);
        chk(f_rd == 0, "R7 zero cfg no pop", f_rd, 0);
        cfg_lo = lo;
        drain("R1 one byte per word");
    endtask

    task automatic t_empty();
        bit seen = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (chr_valid || fifo_pop) seen = 1;
        end
        chk(!seen, "R11 empty fifo quiet", seen, 0);
    endtask

    task automatic t_timing();
        rdy_mode = 0;
        @(negedge clk);
        push(32'h0000_0055, cfg_lo, cfg_hi);
        push(32'h0000_00AA, cfg_lo, cfg_hi);
        #2;
        chk(fifo_pop && !chr_valid, "R9 pop in fetch cycle", {fifo_pop, chr_valid}, 2);
        @(negedge clk);
        chk(chr_valid && !fifo_pop && chr_data == 8'h55, "R9 char one cycle after pop",
            {chr_valid, fifo_pop, chr_data}, {2'b10, 8'h55});
        @(negedge clk);
        chk(!chr_valid && fifo_pop, "R9 gap after last", {chr_valid, fifo_pop}, 1);
        @(negedge clk);
        chk(chr_valid && chr_data == 8'hAA, "R9 next word char", {chr_valid, chr_data}, {1'b1, 8'hAA});
        drain("R9 drain");
    endtask

    task automatic t_four_lsb();
        logic [19:0] lo = {mk(8, 0, 7, 0), mk(0, 0, 7, 0)};
        logic [19:0] hi = {mk(24, 0, 7, 1), mk(16, 0, 7, 0)};
        cfg_lo = lo; cfg_hi = hi;
        rdy_mode = 1;
        push(32'h1122_3344, lo, hi);
        push(32'hDEAD_BEEF, lo, hi);
        push(32'h8001_7FFE, lo, hi);
        drain("R2 four ascending bytes");
        rdy_mode = 0;
    endtask

    task automatic t_msb();
        logic [19:0] lo = {10'd0, mk(7, 1, 7, 1)};
        logic [19:0] hi = '0;
        cfg_lo = lo; cfg_hi = hi;
        push(32'h0000_00C1, lo, hi);
        push(32'hFFFF_FF0F, lo, hi);
        drain("R3 descending single");
        lo = {mk(23, 1, 7, 1), mk(31, 1, 7, 0)};
        hi = {mk(3, 0, 2, 0), mk(1, 0, 1, 0)};
        cfg_lo = lo; cfg_hi = hi;
        rdy_mode = 1;
        push(32'hA5C3_0F00, lo, hi);
        push(32'h1234_5678, lo, hi);
        drain("R5 end mark on step 1");
        rdy_mode = 0;
    endtask

    task automatic t_nostop();
        logic [19:0] lo = {mk(5, 0, 4, 0), mk(0, 0, 4, 0)};
        logic [19:0] hi = {mk(15, 0, 4, 0), mk(10, 0, 4, 0)};
        cfg_lo = lo; cfg_hi = hi;
        push(32'h000F_A5B6, lo, hi);
        push(32'hFFFF_FFFF, lo, hi);
        drain("R6 step 3 closes word");
    endtask

    task automatic t_edge();
        logic [19:0] lo = {mk(2, 1, 7, 0), mk(30, 0, 7, 0)};
        logic [19:0] hi = {10'd0, mk(31, 0, 0, 1)};
        cfg_lo = lo; cfg_hi = hi;
        push(32'hC000_0007, lo, hi);
        push(32'h4000_0005, lo, hi);
        drain("R4 out of range bits");
    endtask

    task automatic t_stall();
        logic [19:0] lo = {mk(8, 0, 7, 1), mk(0, 0, 7, 0)};
        int r0;
        cfg_lo = lo; cfg_hi = '0;
        rdy_mode = 2;
        @(negedge clk);
        @(negedge clk);
        r0 = e_rd;
        push(32'h0000_9A3C, lo, '0);
        repeat (8) @(negedge clk);
        chk(e_rd == r0 && f_rd == f_wr && chr_valid && chr_data == 8'h3C,
            "R8 held without ready", {e_rd - r0, chr_data}, {32'd0, 8'h3C});
        rdy_mode = 0;
        drain("R8 release");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_zero_cfg();
        t_empty();
        t_timing();
        t_four_lsb();
        t_msb();
        t_nostop();
        t_edge();
        t_stall();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", e_rd, e_wr);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule